// File: doc/BRIEF.md
# SDRAM Bank Interruption and Auto-Precharge Tracker

This block follows a registered SDRAM command stream and works out two things, one clock at a time. The first is which bank owns the shared data bus, and in which direction. The second is when each bank begins its internal precharge. A READ or WRITE to any bank may cut short a burst that is still running in another bank. The tracker applies the hand-over rule for each of the four read/write pairings. If the cut-short burst had asked for auto-precharge, the tracker starts that precharge itself.

It also watches the data-mask input ahead of a WRITE that cuts into a read burst. A mask that was not raised early enough could leave the DRAM and the controller driving the bus in the same cycle, so the tracker flags it. CAS latency and the write-recovery time are run-time inputs. The burst length and the bank count are parameters.

Timing convention: a command, its bank, its auto-precharge flag and the mask are sampled at a rising edge. Every output is registered at an edge. After edge e, the bus outputs describe the data beat that belongs to edge e. A precharge pulse or an error flag that is raised after edge e reports an event that occurred at edge e.

Top module: `sdrap_tracker`

## Requirements
- R1: While reset is held, the block drives every output low: no precharge pulse, no bus owner, no error.
- R2: Command code 2'b11 is a WRITE. A WRITE sampled at edge k gives the bus to a write from that bank (bus_wr_o high, bus_bank_o equal to the bank) for edges k to k+BURST_LEN-1, unless a later READ or WRITE cuts it short.
- R3: Command code 2'b10 is a READ. A READ sampled at edge k with CAS latency CL puts read data from its bank on the bus (bus_rd_o high) for edges k+CL to k+CL+BURST_LEN-1. If a read is already running, its data stays on the bus through edge k+CL-1 and is then replaced.
- R4: A WRITE that cuts into a read ends that read's data at the WRITE's own edge. From that edge on, the bus carries the write.
- R5: A READ at edge k that cuts into a write ends the write after its beat at edge k-1. The bus is then idle until the read data starts at edge k+CL.
- R6: A WRITE at edge k that cuts into a write takes the bus from edge k. The old write's last beat is the one at edge k-1.
- R7: A read burst that carries auto-precharge and is cut short at edge k makes its bank's precharge pulse rise after edge k.
- R8: A write burst that carries auto-precharge and is cut short at edge k makes its bank's precharge pulse rise after edge k+tWR. A tWR input of 0 counts as 1.
- R9: A burst that is cut short without auto-precharge produces no precharge pulse for its bank.
- R10: A burst with auto-precharge that runs to the end reaches its end edge at k+BURST_LEN, where k is its command edge. A read pulses after that end edge. A write pulses after that end edge plus tWR.
- R11: A WRITE can cut into a read within BURST_LEN-1 edges of the read command. When it does, the mask must have been high at the edge before the WRITE. If the read carried auto-precharge, the mask must also have been high two edges before. If this is not met, dqm_err_o rises for one cycle after the WRITE's edge.
- R12: Each precharge pulse and each error flag lasts one cycle. Codes 2'b00 (NOP) and 2'b01 (ACTIVE) change no output.
- R13: CAS latency is taken from cas_lat_i (2 or 3) when each READ is sampled. Both values give the timing of R3 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Command: 00 NOP, 01 ACTIVE, 10 READ, 11 WRITE |
| bank_i | input | BANK_W | Bank addressed by the command |
| ap_i | input | 1 | Auto-precharge request for READ/WRITE |
| dqm_i | input | 1 | Data mask sampled at each edge |
| cas_lat_i | input | 2 | CAS latency, 2 or 3 |
| twr_i | input | TWR_W | Write recovery time in clocks |
| pre_start_o | output | NUM_BANKS | One-cycle precharge-start pulse per bank |
| bus_rd_o | output | 1 | Read data on the bus at the last edge |
| bus_wr_o | output | 1 | Write data on the bus at the last edge |
| bus_bank_o | output | BANK_W | Bank owning the bus when rd or wr is high |
| dqm_err_o | output | 1 | Mask timing violation on a read-to-write interruption |

## Verification
The future-beat schedule might hold a stale or misplaced entry. That would show up at the bus outputs no later than CL+BURST_LEN edges after the command that should have reshaped it: as a wrong owner, a wrong direction, or an idle gap of the wrong length. A wrong record of the open burst would show up at the next interrupting command, or at the natural end edge, as a precharge pulse that is missing, extra or shifted. A timer that counts wrongly would move a write's pulse away from its edge plus tWR. Each of these is compared on every clock against an independently computed schedule, at both CAS latencies and with the mask timed correctly and wrongly.

// File: rtl/sdrap_pkg.sv
package sdrap_pkg;
   typedef enum logic [1:0] {
      CMD_NOP = 2'b00,
      CMD_ACT = 2'b01,
      CMD_RD  = 2'b10,
      CMD_WR  = 2'b11
   } cmd_e;

   typedef enum logic [1:0] {
      SK_IDLE = 2'b00,
      SK_RD   = 2'b01,
      SK_WR   = 2'b10
   } slot_kind_e;
endpackage

// File: rtl/sdrap_burst_track.sv
module sdrap_burst_track #(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned BURST_LEN = 4,
   localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int unsigned LEFT_W = $clog2(BURST_LEN + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 new_rd,
   input  logic                 new_wr,
   input  logic [BANK_W-1:0]    new_bank,
   input  logic                 new_ap,
   output logic [NUM_BANKS-1:0] fin_rd_ap,
   output logic [NUM_BANKS-1:0] fin_wr_ap,
   output logic                 rd_open,
   output logic                 open_ap
);
   logic              act_q;
   logic              wr_q;
   logic              ap_q;
   logic [BANK_W-1:0] bank_q;
   logic [LEFT_W-1:0] left_q;
   logic              issue;
   logic              end_now;

   assign issue   = new_rd | new_wr;
   // the open burst ends at this edge: cut short, or its last beat has gone
   assign end_now = act_q & (issue | (left_q == '0));
   assign rd_open = act_q & ~wr_q & (left_q != '0);
   assign open_ap = ap_q;

   always_comb begin
      fin_rd_ap = '0;
      fin_wr_ap = '0;
      if (end_now && ap_q) begin
         if (wr_q) fin_wr_ap[bank_q] = 1'b1;
         else      fin_rd_ap[bank_q] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         wr_q   <= 1'b0;
         ap_q   <= 1'b0;
         bank_q <= '0;
         left_q <= '0;
      end else if (issue) begin
         act_q  <= 1'b1;
         wr_q   <= new_wr;
         ap_q   <= new_ap;
         bank_q <= new_bank;
         left_q <= LEFT_W'(BURST_LEN - 1);
      end else if (end_now) begin
         act_q  <= 1'b0;
      end else if (act_q) begin
         left_q <= left_q - 1'b1;
      end
   end

   // R9
   no_ap_no_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !$past(issue) && !ap_q) |-> (fin_rd_ap == '0 && fin_wr_ap == '0));
endmodule

// File: rtl/sdrap_bus_sched.sv
module sdrap_bus_sched
   import sdrap_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned BURST_LEN = 4,
   parameter int unsigned CL_MAX    = 3,
   localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int unsigned DEPTH  = CL_MAX + BURST_LEN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              new_rd,
   input  logic              new_wr,
   input  logic [BANK_W-1:0] new_bank,
   input  logic [1:0]        cas_lat,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic [BANK_W-1:0] bus_bank
);
   // slot j holds the owner of the data beat that belongs to edge (now + j)
   slot_kind_e        kind_q [DEPTH];
   slot_kind_e        kind_n [DEPTH];
   logic [BANK_W-1:0] bk_q   [DEPTH];
   logic [BANK_W-1:0] bk_n   [DEPTH];
   int                cl_i;

   assign cl_i = int'(cas_lat);

   always_comb begin
      for (int j = 0; j < int'(DEPTH) - 1; j++) begin
         kind_n[j] = kind_q[j+1];
         bk_n[j]   = bk_q[j+1];
      end
      kind_n[DEPTH-1] = SK_IDLE;
      bk_n[DEPTH-1]   = '0;
      for (int j = 0; j < int'(DEPTH); j++) begin
         if (new_wr) begin
            // a write owns the bus from its own edge; all else is dropped
            if (j < int'(BURST_LEN)) begin
               kind_n[j] = SK_WR;
               bk_n[j]   = new_bank;
            end else begin
               kind_n[j] = SK_IDLE;
               bk_n[j]   = '0;
            end
         end else if (new_rd) begin
            if (j < cl_i) begin
               // earlier read data still drains; write beats are cut
               if (kind_n[j] != SK_RD) begin
                  kind_n[j] = SK_IDLE;
                  bk_n[j]   = '0;
               end
            end else if (j < cl_i + int'(BURST_LEN)) begin
               kind_n[j] = SK_RD;
               bk_n[j]   = new_bank;
            end else begin
               kind_n[j] = SK_IDLE;
               bk_n[j]   = '0;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j < int'(DEPTH); j++) begin
            kind_q[j] <= SK_IDLE;
            bk_q[j]   <= '0;
         end
      end else begin
         for (int j = 0; j < int'(DEPTH); j++) begin
            kind_q[j] <= kind_n[j];
            bk_q[j]   <= bk_n[j];
         end
      end
   end

   assign bus_rd   = (kind_q[0] == SK_RD);
   assign bus_wr   = (kind_q[0] == SK_WR);
   assign bus_bank = bk_q[0];

   // R2
   wr_takes_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      new_wr |=> (bus_wr && bus_bank == $past(new_bank)));

   // R5
   rd_cuts_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (new_rd && !new_wr) |=> !bus_wr);
endmodule

// File: rtl/sdrap_pre_timer.sv
module sdrap_pre_timer #(
   parameter int unsigned TWR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_now,
   input  logic             go_wr,
   input  logic [TWR_W-1:0] twr,
   output logic             pulse
);
   logic             pend_q;
   logic [TWR_W-1:0] cnt_q;
   logic [TWR_W-1:0] twr_eff;

   assign twr_eff = (twr == '0) ? TWR_W'(1) : twr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
         pulse  <= 1'b0;
      end else begin
         pulse <= go_now;
         if (go_wr) begin
            pend_q <= 1'b1;
            cnt_q  <= twr_eff;
         end else if (pend_q) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == TWR_W'(1)) begin
               pend_q <= 1'b0;
               pulse  <= 1'b1;
            end
         end
      end
   end

   // R7
   read_pre_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_now |=> pulse);

   // R8
   write_pre_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && cnt_q == TWR_W'(1) && !go_wr) |=> (pulse && !pend_q));
endmodule

// File: rtl/sdrap_tracker.sv
module sdrap_tracker
   import sdrap_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned BURST_LEN = 4,
   parameter int unsigned CL_MAX    = 3,
   parameter int unsigned TWR_W     = 4,
   localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           cmd_i,
   input  logic [BANK_W-1:0]    bank_i,
   input  logic                 ap_i,
   input  logic                 dqm_i,
   input  logic [1:0]           cas_lat_i,
   input  logic [TWR_W-1:0]     twr_i,
   output logic [NUM_BANKS-1:0] pre_start_o,
   output logic                 bus_rd_o,
   output logic                 bus_wr_o,
   output logic [BANK_W-1:0]    bus_bank_o,
   output logic                 dqm_err_o
);
   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("NUM_BANKS must be at least 2");
   end
   if (BURST_LEN < 1 || BURST_LEN > 64) begin : g_bad_burst
      $error("BURST_LEN must lie in 1..64");
   end
   if (CL_MAX < 2 || CL_MAX > 3) begin : g_bad_cl
      $error("CL_MAX must be 2 or 3");
   end
   if (TWR_W < 1 || TWR_W > 8) begin : g_bad_twr
      $error("TWR_W must lie in 1..8");
   end

   logic                 is_rd;
   logic                 is_wr;
   logic                 dqm_d1;
   logic                 dqm_d2;
   logic                 rd_open;
   logic                 open_ap;
   logic                 mask_ok;
   logic [NUM_BANKS-1:0] fin_rd_ap;
   logic [NUM_BANKS-1:0] fin_wr_ap;

   assign is_rd = (cmd_i == CMD_RD);
   assign is_wr = (cmd_i == CMD_WR);

   sdrap_burst_track #(
      .NUM_BANKS(NUM_BANKS),
      .BURST_LEN(BURST_LEN)
   ) burst_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .new_rd   (is_rd),
      .new_wr   (is_wr),
      .new_bank (bank_i),
      .new_ap   (ap_i),
      .fin_rd_ap(fin_rd_ap),
      .fin_wr_ap(fin_wr_ap),
      .rd_open  (rd_open),
      .open_ap  (open_ap)
   );

   sdrap_bus_sched #(
      .NUM_BANKS(NUM_BANKS),
      .BURST_LEN(BURST_LEN),
      .CL_MAX   (CL_MAX)
   ) bus_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .new_rd  (is_rd),
      .new_wr  (is_wr),
      .new_bank(bank_i),
      .cas_lat (cas_lat_i),
      .bus_rd  (bus_rd_o),
      .bus_wr  (bus_wr_o),
      .bus_bank(bus_bank_o)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      sdrap_pre_timer #(
         .TWR_W(TWR_W)
      ) timer_i (
         .clk   (clk),
         .rst_n (rst_n),
         .go_now(fin_rd_ap[b]),
         .go_wr (fin_wr_ap[b]),
         .twr   (twr_i),
         .pulse (pre_start_o[b])
      );
   end

   // mask lead required ahead of a write that cuts into a read
   assign mask_ok = dqm_d1 & (~open_ap | dqm_d2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dqm_d1    <= 1'b0;
         dqm_d2    <= 1'b0;
         dqm_err_o <= 1'b0;
      end else begin
         dqm_d1    <= dqm_i;
         dqm_d2    <= dqm_d1;
         dqm_err_o <= is_wr & rd_open & ~mask_ok;
      end
   end

   // R11
   err_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dqm_err_o |-> $past(is_wr));

   // R13
   cas_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_rd |-> (int'(cas_lat_i) >= 2 && int'(cas_lat_i) <= int'(CL_MAX)));

   // R4
   wr_ends_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_wr |=> !bus_rd_o);
endmodule

// File: tb/sdrap_tracker_tb_top.sv
`timescale 1ns/1ps
module sdrap_tracker_tb_top;
   localparam int BL   = 4;
   localparam int NB   = 4;
   localparam int HMAX = 1200;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cmd = 2'b00;
   logic [1:0] bank = 2'b00;
   logic       ap = 1'b0;
   logic       dqm = 1'b0;
   logic [1:0] cl = 2'd2;
   logic [3:0] tw = 4'd2;
   logic [NB-1:0] pre_o;
   logic       brd_o, bwr_o, err_o;
   logic [1:0] bbk_o;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;

   int exp_kind [HMAX];
   int exp_bk   [HMAX];
   int exp_pre  [HMAX];
   bit exp_err  [HMAX];
   bit dqm_h    [HMAX];

   bit rb_valid = 0;
   bit rb_wr = 0;
   bit rb_ap = 0;
   int rb_bank = 0;
   int rb_end = 0;

   always #4 clk = ~clk;

   sdrap_tracker #(.NUM_BANKS(NB), .BURST_LEN(BL), .CL_MAX(3), .TWR_W(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .ap_i(ap),
      .dqm_i(dqm), .cas_lat_i(cl), .twr_i(tw), .pre_start_o(pre_o),
      .bus_rd_o(brd_o), .bus_wr_o(bwr_o), .bus_bank_o(bbk_o), .dqm_err_o(err_o)
   );

   initial begin
      for (int i = 0; i < HMAX; i++) begin
         exp_kind[i] = 0; exp_bk[i] = 0; exp_pre[i] = 0; exp_err[i] = 0; dqm_h[i] = 0;
      end
   end

   // reference model: absolute-time schedule filled at each sampled command
   always @(posedge clk) begin : model_b
      int e;
      int twe;
      int c;
      bit rdwr;
      if (rst_n) begin
         e = cyc;
         c = int'(cl);
         twe = (tw == 0) ? 1 : int'(tw);
         dqm_h[e] = dqm;
         rdwr = (cmd == 2'b10) || (cmd == 2'b11);
         if (cmd == 2'b11 && rb_valid && !rb_wr && e < rb_end) begin
            if (!(e >= 1 && dqm_h[e-1] && (!rb_ap || (e >= 2 && dqm_h[e-2]))))
               exp_err[e] = 1;
         end
         if (rb_valid && (e == rb_end || (rdwr && e < rb_end))) begin
            if (rb_ap) begin
               if (rb_wr) exp_pre[e+twe] = exp_pre[e+twe] | (1 << rb_bank);
               else       exp_pre[e]     = exp_pre[e] | (1 << rb_bank);
            end
            rb_valid = 0;
         end
         if (cmd == 2'b11) begin
            for (int t = e; t < e + 20; t++) begin exp_kind[t] = 0; exp_bk[t] = 0; end
            for (int t = e; t < e + BL; t++) begin exp_kind[t] = 2; exp_bk[t] = int'(bank); end
         end else if (cmd == 2'b10) begin
            for (int t = e; t < e + c; t++)
               if (exp_kind[t] == 2) begin exp_kind[t] = 0; exp_bk[t] = 0; end
            for (int t = e + c; t < e + c + BL; t++) begin exp_kind[t] = 1; exp_bk[t] = int'(bank); end
            for (int t = e + c + BL; t < e + 20; t++) begin exp_kind[t] = 0; exp_bk[t] = 0; end
         end
         if (rdwr) begin
            rb_valid = 1; rb_wr = (cmd == 2'b11); rb_ap = ap;
            rb_bank = int'(bank); rb_end = e + BL;
         end
         cyc = cyc + 1;
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin : cmp_b
      int t;
      int gk;
      if (rst_n && cyc > 0 && !done) begin
         t = cyc - 1;
         gk = brd_o ? 1 : (bwr_o ? 2 : 0);
         if (brd_o && bwr_o) gk = 3;
         n_chk++;
         if (gk != exp_kind[t] || (gk != 0 && int'(bbk_o) != exp_bk[t])) begin
            n_fail++;
            $display("FAIL R2 R3 R4 R5 R6 R13 bus at edge %0d: kind=%0d bank=%0d expected kind=%0d bank=%0d",
                     t, gk, bbk_o, exp_kind[t], exp_bk[t]);
         end
         n_chk++;
         if (int'(pre_o) != exp_pre[t]) begin
            n_fail++;
            $display("FAIL R7 R8 R9 R10 R12 precharge at edge %0d: got %b expected %b",
                     t, pre_o, exp_pre[t][NB-1:0]);
         end
         n_chk++;
         if (err_o != exp_err[t]) begin
            n_fail++;
            $display("FAIL R11 R12 mask error at edge %0d: got %0b expected %0b",
                     t, err_o, exp_err[t]);
         end
      end
   end

   task automatic step(input logic [1:0] c, input int b, input logic a, input logic m);
      cmd = c; bank = 2'(b); ap = a; dqm = m;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic gap(input int n);
      for (int i = 0; i < n; i++) step(2'b00, 0, 1'b0, 1'b0);
   endtask

   initial begin : wdog_b
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired: got hung run expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main_b
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      n_chk++;
      if (pre_o != '0 || brd_o || bwr_o || err_o || bbk_o != '0) begin
         n_fail++;
         $display("FAIL R1 reset: got pre=%b rd=%0b wr=%0b err=%0b expected all zero",
                  pre_o, brd_o, bwr_o, err_o);
      end
      rst_n = 1'b1;
      gap(2);
      for (int p = 0; p < 2; p++) begin
         cl = (p == 0) ? 2'd2 : 2'd3;   // R13 both latencies
         tw = (p == 0) ? 4'd2 : 4'd3;
         gap(2);
         // R3 R7: read with AP cut by read
         step(2'b10, 0, 1'b1, 1'b0); step(2'b00, 0, 1'b0, 1'b0); step(2'b10, 1, 1'b0, 1'b0); gap(14);
         // R4 R9 R10: read without AP cut by write with AP, mask one edge ahead
         step(2'b10, 2, 1'b0, 1'b0); step(2'b00, 0, 1'b0, 1'b1); step(2'b11, 3, 1'b1, 1'b0); gap(14);
         // R11: read with AP, mask only one edge ahead -> error
         step(2'b10, 1, 1'b1, 1'b0); step(2'b00, 0, 1'b0, 1'b1); step(2'b11, 0, 1'b0, 1'b0); gap(14);
         // R11: read with AP, mask two edges ahead -> no error
         step(2'b10, 1, 1'b1, 1'b1); step(2'b00, 0, 1'b0, 1'b1); step(2'b11, 2, 1'b0, 1'b0); gap(14);
         // R11 R12: read cut by write after ACTIVE with no mask -> error
         step(2'b10, 3, 1'b0, 1'b0); step(2'b01, 2, 1'b1, 1'b0); step(2'b11, 1, 1'b0, 1'b0); gap(14);
         // R5 R8 R10: write with AP cut by read with AP
         step(2'b11, 0, 1'b1, 1'b0); step(2'b00, 0, 1'b0, 1'b0); step(2'b10, 2, 1'b1, 1'b0); gap(14);
         // R6 R8: write with AP cut by write
         step(2'b11, 1, 1'b1, 1'b0); step(2'b11, 3, 1'b0, 1'b0); gap(14);
         // R5 R9: write without AP cut by read
         step(2'b11, 2, 1'b0, 1'b0); step(2'b10, 0, 1'b0, 1'b0); gap(14);
         // R10 R11: write at the read's natural end edge is not an interruption
         step(2'b10, 0, 1'b0, 1'b0); gap(3); step(2'b11, 1, 1'b0, 1'b0); gap(14);
         // R2 R10: lone write with AP ends naturally
         step(2'b11, 3, 1'b1, 1'b0); gap(14);
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule